// File: doc/BRIEF.md
# Pseudo-static RAM power-mode sequencer

This block owns the two chip-enable pins of an asynchronous pseudo-static RAM and sequences its power states. Out of reset it holds the memory in a power-on wait with the deselect enable high and the power-down enable high, for a parameterised number of nanoseconds, before any access is allowed. It then sits in standby until the access controller asks for the memory. When that happens it drives chip enable 1 low and grants the bus.

A host can send the memory into deep power-down with a level sleep request and bring it back with a wake request. Entry always passes through standby, with chip enable 1 high. It waits a setup time before chip enable 2 falls, then keeps chip enable 2 low for a minimum time. A wake that arrives inside that minimum is remembered and acted on when the minimum ends. Leaving power-down starts a long recovery wait with chip enable 1 still high.

A strobe-hold output forces the output-enable and write-enable lines inactive whenever chip enable 1 is high. After every release of the bus, the block stays in standby for a guard time before it grants again. All durations are given in nanoseconds and converted to clock cycles, rounded up, from a clock-period parameter.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is low and for exactly ceil(POR_WAIT_NS/CLK_PERIOD_NS) rising edges after its release, mode is 0 (init), ce1N and ce2 are 1, strobeHold is 1, and accGrant and ready are 0. A reset applied in any state returns these values at once.
- R2: ready is 1 exactly when mode is 1 (standby) or 2 (active).
- R3: In standby with accReq high and the guard time elapsed, the next edge enters active: mode 2, ce1N 0, accGrant 1, strobeHold 0, ce2 1.
- R4: Active is left for standby only on an edge where accIdle is 1 and either accReq is 0 or sleepReq is 1. While accIdle is 0, the block stays active.
- R5: After each entry to standby, accGrant stays 0 for ceil(STBY_GUARD_NS/CLK_PERIOD_NS) edges, even if accReq is high.
- R6: A sleep request made while active is not acted on until accIdle is 1.
- R7: sleepReq high in standby enters the power-down setup on the next edge: mode 3, ce1N 1, ce2 1. ce2 falls after ceil(PD_SETUP_NS/CLK_PERIOD_NS) edges in that phase.
- R8: Once ce2 is low it stays low for at least ceil(PD_HOLD_NS/CLK_PERIOD_NS) edges. A wakeReq pulse inside that window is held and acted on when the window ends.
- R9: A wake from power-down raises ce2 and enters the wake wait (mode 4, ce1N 1). The wake wait lasts ceil(WAKE_WAIT_NS/CLK_PERIOD_NS) edges and then returns to standby.
- R10: wakeReq in standby or active has no effect. sleepReq and accReq during the wake wait have no effect.
- R11: ce2 is 0 only while ce1N is 1.
- R12: mode encodes 0=init, 1=standby, 2=active, 3=power-down (setup, minimum hold and resident), 4=waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Host level request to enter deep power-down |
| wakeReq | input | 1 | Host request to leave deep power-down |
| accReq | input | 1 | Access controller wants the memory |
| accIdle | input | 1 | Access controller has no cycle in flight |
| ce1N | output | 1 | Memory chip enable 1, active low |
| ce2 | output | 1 | Memory chip enable 2, low puts the memory in deep power-down |
| strobeHold | output | 1 | Forces output enable and write enable inactive |
| accGrant | output | 1 | Access controller may drive cycles |
| ready | output | 1 | Memory usable (standby or active) |
| mode | output | 3 | Current power mode, encoding as in R12 |

## Verification
The bench counts edges to the exact boundary of each timed phase: power-on, guard, setup, minimum low and wake. A design that is off by one in its timer would show the wrong mode at one of those sampled edges. A wake pulse is sent inside the minimum-low window. A design that dropped it would stay in power-down, and one that acted on it at once would raise ce2 too early. A sleep request is held while the access controller is busy. A design that skipped the idle check would drop the grant with a cycle still in flight. Reset is applied while ce2 is low to show that it returns at once to the power-on state.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [2:0] {
    ST_POR, ST_STBY, ST_ACT, ST_PDSU, ST_PDHOLD, ST_PD, ST_WAKE
  } pwrState_e;

  typedef enum logic [2:0] {
    DUR_POR, DUR_GUARD, DUR_SETUP, DUR_HOLD, DUR_WAKE
  } durSel_e;

  // control -> timer strobes
  typedef struct packed {
    logic    load;
    durSel_e sel;
  } tmrStrobe_t;

  localparam logic [2:0] MODE_INIT  = 3'd0;
  localparam logic [2:0] MODE_STBY  = 3'd1;
  localparam logic [2:0] MODE_ACT   = 3'd2;
  localparam logic [2:0] MODE_PDOWN = 3'd3;
  localparam logic [2:0] MODE_WAKE  = 3'd4;

  function automatic int unsigned nsToCycles(int unsigned ns, int unsigned periodNs);
    int unsigned c;
    c = (ns + periodNs - 1) / periodNs;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/pwr_timer.sv
module pwr_timer
  import psram_pwr_pkg::*;
#(
  parameter int unsigned POR_CYC   = 75000,
  parameter int unsigned GUARD_CYC = 3,
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned HOLD_CYC  = 18,
  parameter int unsigned WAKE_CYC  = 75000,
  parameter int unsigned TW        = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  tmrStrobe_t stb,
  output logic       done
);

  logic [TW-1:0] count;
  logic [TW-1:0] loadVal;

  always_comb begin
    case (stb.sel)
      DUR_POR:   loadVal = TW'(POR_CYC);
      DUR_GUARD: loadVal = TW'(GUARD_CYC);
      DUR_SETUP: loadVal = TW'(SETUP_CYC);
      DUR_HOLD:  loadVal = TW'(HOLD_CYC);
      default:   loadVal = TW'(WAKE_CYC);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= TW'(POR_CYC);
    else if (stb.load)       count <= loadVal;
    else if (count != '0)    count <= count - 1'b1;
  end

  // the current state has used its last cycle when count is one or less
  assign done = (count <= TW'(1));

endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
  import psram_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleepReq,
  input  logic       wakeReq,
  input  logic       accReq,
  input  logic       accIdle,
  input  logic       tmrDone,
  output tmrStrobe_t stb,
  output logic       ce1N,
  output logic       ce2,
  output logic       strobeHold,
  output logic       accGrant,
  output logic       ready,
  output logic [2:0] mode
);

  pwrState_e st, nxt;
  logic      wakePend;

  always_comb begin
    nxt = st;
    stb = '{load: 1'b0, sel: DUR_GUARD};
    case (st)
      ST_POR: if (tmrDone) begin
        nxt = ST_STBY; stb = '{load: 1'b1, sel: DUR_GUARD};
      end
      ST_STBY: begin
        if (sleepReq) begin
          nxt = ST_PDSU; stb = '{load: 1'b1, sel: DUR_SETUP};
        end else if (accReq && tmrDone) begin
          nxt = ST_ACT;
        end
      end
      ST_ACT: if (accIdle && (sleepReq || !accReq)) begin
        nxt = ST_STBY; stb = '{load: 1'b1, sel: DUR_GUARD};
      end
      ST_PDSU: if (tmrDone) begin
        nxt = ST_PDHOLD; stb = '{load: 1'b1, sel: DUR_HOLD};
      end
      ST_PDHOLD: if (tmrDone) begin
        if (wakePend || wakeReq) begin
          nxt = ST_WAKE; stb = '{load: 1'b1, sel: DUR_WAKE};
        end else begin
          nxt = ST_PD;
        end
      end
      ST_PD: if (wakeReq) begin
        nxt = ST_WAKE; stb = '{load: 1'b1, sel: DUR_WAKE};
      end
      ST_WAKE: if (tmrDone) begin
        nxt = ST_STBY; stb = '{load: 1'b1, sel: DUR_GUARD};
      end
      default: begin
        nxt = ST_POR; stb = '{load: 1'b1, sel: DUR_POR};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_POR;
      wakePend <= 1'b0;
    end else begin
      st       <= nxt;
      wakePend <= (st == ST_PDHOLD) && (wakePend || wakeReq);
    end
  end

  always_comb begin
    ce1N       = (st != ST_ACT);
    ce2        = !((st == ST_PDHOLD) || (st == ST_PD));
    accGrant   = (st == ST_ACT);
    strobeHold = (st != ST_ACT);
    ready      = (st == ST_STBY) || (st == ST_ACT);
    case (st)
      ST_POR:                   mode = MODE_INIT;
      ST_STBY:                  mode = MODE_STBY;
      ST_ACT:                   mode = MODE_ACT;
      ST_PDSU, ST_PDHOLD, ST_PD: mode = MODE_PDOWN;
      default:                  mode = MODE_WAKE;
    endcase
  end

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned POR_WAIT_NS   = 300000,
  parameter int unsigned WAKE_WAIT_NS  = 300000,
  parameter int unsigned PD_SETUP_NS   = 10,
  parameter int unsigned PD_HOLD_NS    = 70,
  parameter int unsigned STBY_GUARD_NS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleepReq,
  input  logic       wakeReq,
  input  logic       accReq,
  input  logic       accIdle,
  output logic       ce1N,
  output logic       ce2,
  output logic       strobeHold,
  output logic       accGrant,
  output logic       ready,
  output logic [2:0] mode
);

  localparam int unsigned PorCyc   = nsToCycles(POR_WAIT_NS, CLK_PERIOD_NS);
  localparam int unsigned WakeCyc  = nsToCycles(WAKE_WAIT_NS, CLK_PERIOD_NS);
  localparam int unsigned SetupCyc = nsToCycles(PD_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned HoldCyc  = nsToCycles(PD_HOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned GuardCyc = nsToCycles(STBY_GUARD_NS, CLK_PERIOD_NS);
  localparam int unsigned MaxA     = (PorCyc > WakeCyc) ? PorCyc : WakeCyc;
  localparam int unsigned MaxB     = (SetupCyc > HoldCyc) ? SetupCyc : HoldCyc;
  localparam int unsigned MaxC     = (MaxB > GuardCyc) ? MaxB : GuardCyc;
  localparam int unsigned MaxCyc   = (MaxA > MaxC) ? MaxA : MaxC;
  localparam int unsigned TW       = $clog2(MaxCyc + 1);

  tmrStrobe_t tmrStb;
  logic       tmrDone;

  pwr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .accReq(accReq), .accIdle(accIdle), .tmrDone(tmrDone), .stb(tmrStb),
    .ce1N(ce1N), .ce2(ce2), .strobeHold(strobeHold), .accGrant(accGrant),
    .ready(ready), .mode(mode)
  );

  pwr_timer #(
    .POR_CYC(PorCyc), .GUARD_CYC(GuardCyc), .SETUP_CYC(SetupCyc),
    .HOLD_CYC(HoldCyc), .WAKE_CYC(WakeCyc), .TW(TW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .stb(tmrStb), .done(tmrDone)
  );

endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker #(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned PD_HOLD_NS    = 70,
  parameter int unsigned STBY_GUARD_NS = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       accIdle,
  input logic       ce1N,
  input logic       ce2,
  input logic       strobeHold,
  input logic       accGrant,
  input logic       ready,
  input logic [2:0] mode
);

  localparam int unsigned HoldCyc  = psram_pwr_pkg::nsToCycles(PD_HOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned GuardCyc = psram_pwr_pkg::nsToCycles(STBY_GUARD_NS, CLK_PERIOD_NS);

  logic [15:0] lowCnt;   // cycles ce2 has been low
  logic [15:0] highCnt;  // cycles ce1N has been high

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowCnt  <= '0;
      highCnt <= '0;
    end else begin
      lowCnt  <= ce2 ? '0 : ((lowCnt == 16'hFFFF) ? lowCnt : lowCnt + 1'b1);
      highCnt <= !ce1N ? '0 : ((highCnt == 16'hFFFF) ? highCnt : highCnt + 1'b1);
    end
  end

  a_r11_ce2_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !ce2 |-> ce1N);

  a_r3_grant_enables_chip: assert property (@(posedge clk) disable iff (!rst_n)
    accGrant |-> (!ce1N && !strobeHold && ce2));

  a_r2_ready_matches_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ready == ((mode == 3'd1) || (mode == 3'd2)));

  a_r8_ce2_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce2) |-> (lowCnt >= 16'(HoldCyc)));

  a_r5_guard_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce1N) |-> (highCnt >= 16'(GuardCyc)));

  a_r6_busy_keeps_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (accGrant && !accIdle) |=> accGrant);

  a_r9_wake_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> (ce1N && ce2));

endmodule

bind psram_pwr_seq pwr_seq_checker #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .PD_HOLD_NS(PD_HOLD_NS), .STBY_GUARD_NS(STBY_GUARD_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .accIdle(accIdle), .ce1N(ce1N), .ce2(ce2),
  .strobeHold(strobeHold), .accGrant(accGrant), .ready(ready), .mode(mode)
);

// File: tb/test_psram_pwr_seq.sv
module test_psram_pwr_seq;

  // 4 ns period: POR 50, wake 30, setup 3, hold 18, guard 3 cycles
  localparam int unsigned PorC = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleepReq = 1'b0, wakeReq = 1'b0, accReq = 1'b0, accIdle = 1'b1;
  logic ce1N, ce2, strobeHold, accGrant, ready;
  logic [2:0] mode;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  psram_pwr_seq #(
    .CLK_PERIOD_NS(4), .POR_WAIT_NS(200), .WAKE_WAIT_NS(120),
    .PD_SETUP_NS(10), .PD_HOLD_NS(70), .STBY_GUARD_NS(10)
  ) i_psram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .accReq(accReq), .accIdle(accIdle), .ce1N(ce1N), .ce2(ce2),
    .strobeHold(strobeHold), .accGrant(accGrant), .ready(ready), .mode(mode)
  );

  typedef struct packed {
    logic       sl, wk, ar, ai;
    logic [7:0] n;
    logic [2:0] m;
    logic       c1, c2, g;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0, 8'd1,  3'd2,1'b0,1'b1,1'b1, 4'd3},  // 0  R3 grant
    '{1'b1,1'b0,1'b1,1'b0, 8'd4,  3'd2,1'b0,1'b1,1'b1, 4'd6},  // 1  R6 sleep while busy held off
    '{1'b0,1'b0,1'b0,1'b1, 8'd1,  3'd1,1'b1,1'b1,1'b0, 4'd4},  // 2  R4 release to standby
    '{1'b0,1'b0,1'b1,1'b0, 8'd2,  3'd1,1'b1,1'b1,1'b0, 4'd5},  // 3  R5 guard blocks grant
    '{1'b0,1'b0,1'b1,1'b0, 8'd1,  3'd2,1'b0,1'b1,1'b1, 4'd5},  // 4  R5 guard over
    '{1'b0,1'b0,1'b0,1'b0, 8'd2,  3'd2,1'b0,1'b1,1'b1, 4'd4},  // 5  R4 busy keeps active
    '{1'b0,1'b0,1'b0,1'b1, 8'd1,  3'd1,1'b1,1'b1,1'b0, 4'd4},  // 6  R4
    '{1'b1,1'b0,1'b0,1'b1, 8'd1,  3'd3,1'b1,1'b1,1'b0, 4'd7},  // 7  R7 setup entered
    '{1'b1,1'b0,1'b0,1'b1, 8'd2,  3'd3,1'b1,1'b1,1'b0, 4'd7},  // 8  R7 ce2 still high
    '{1'b1,1'b0,1'b0,1'b1, 8'd1,  3'd3,1'b1,1'b0,1'b0, 4'd7},  // 9  R7 ce2 falls
    '{1'b0,1'b1,1'b0,1'b1, 8'd1,  3'd3,1'b1,1'b0,1'b0, 4'd8},  // 10 R8 early wake deferred
    '{1'b0,1'b0,1'b0,1'b1, 8'd16, 3'd3,1'b1,1'b0,1'b0, 4'd8},  // 11 R8 still held low
    '{1'b0,1'b0,1'b0,1'b1, 8'd1,  3'd4,1'b1,1'b1,1'b0, 4'd8},  // 12 R8 deferred wake acted on
    '{1'b1,1'b0,1'b1,1'b0, 8'd29, 3'd4,1'b1,1'b1,1'b0, 4'd10}, // 13 R10 requests ignored in wake wait
    '{1'b0,1'b0,1'b0,1'b1, 8'd1,  3'd1,1'b1,1'b1,1'b0, 4'd9},  // 14 R9 wake wait ends
    '{1'b1,1'b0,1'b0,1'b1, 8'd1,  3'd3,1'b1,1'b1,1'b0, 4'd7},  // 15 R7
    '{1'b1,1'b0,1'b0,1'b1, 8'd3,  3'd3,1'b1,1'b0,1'b0, 4'd7},  // 16 R7
    '{1'b0,1'b0,1'b0,1'b1, 8'd18, 3'd3,1'b1,1'b0,1'b0, 4'd12}, // 17 R12 resident power-down
    '{1'b0,1'b0,1'b0,1'b1, 8'd10, 3'd3,1'b1,1'b0,1'b0, 4'd11}, // 18 R11
    '{1'b0,1'b1,1'b0,1'b1, 8'd1,  3'd4,1'b1,1'b1,1'b0, 4'd9},  // 19 R9 wake
    '{1'b0,1'b0,1'b0,1'b1, 8'd30, 3'd1,1'b1,1'b1,1'b0, 4'd9},  // 20 R9 wake length
    '{1'b0,1'b1,1'b0,1'b1, 8'd3,  3'd1,1'b1,1'b1,1'b0, 4'd10}, // 21 R10 wake in standby ignored
    '{1'b0,1'b0,1'b1,1'b0, 8'd1,  3'd2,1'b0,1'b1,1'b1, 4'd3}   // 22 R3
  };

  task automatic check(string tag, logic [2:0] m, logic c1, logic c2, logic g);
    logic [7:0] act, exp;
    act = {mode, ce1N, ce2, accGrant, ready, strobeHold};
    // R2: ready in modes 1 and 2; strobe hold whenever not granted
    exp = {m, c1, c2, g, (m == 3'd1) || (m == 3'd2), !g};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s {mode,ce1N,ce2,grant,ready,hold} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 / R12: state held in reset
    repeat (3) @(negedge clk);
    check("R1 in reset", 3'd0, 1'b1, 1'b1, 1'b0);
    rst_n = 1'b1;
    repeat (PorC - 1) @(posedge clk);
    @(negedge clk);
    check("R1 last POR cycle", 3'd0, 1'b1, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R1 POR ends in standby", 3'd1, 1'b1, 1'b1, 1'b0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R10 idle standby", 3'd1, 1'b1, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      sleepReq = VEC[i].sl; wakeReq = VEC[i].wk;
      accReq = VEC[i].ar;   accIdle = VEC[i].ai;
      repeat (int'(VEC[i].n)) @(posedge clk);
      @(negedge clk);
      check($sformatf("vector %0d req R%0d", i, VEC[i].req), VEC[i].m, VEC[i].c1, VEC[i].c2, VEC[i].g);
    end

    // R6 / R7: sleep from active once idle, through to ce2 low
    sleepReq = 1'b1; wakeReq = 1'b0; accReq = 1'b0; accIdle = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R7 active to ce2 low", 3'd3, 1'b1, 1'b0, 1'b0);

    // R1: reset while ce2 low
    rst_n = 1'b0; sleepReq = 1'b0;
    #1;
    check("R1 reset during power-down", 3'd0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (PorC) @(posedge clk);
    @(negedge clk);
    check("R1 POR after reset", 3'd1, 1'b1, 1'b1, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule